// File: doc/BRIEF.md
# Steerable Two-Output Interrupt Controller

This block gathers up to sixteen level-sensitive interrupt requests and presents them to a processor on two active-low request lines: a normal line and a fast line. Fifteen requests come from hardware. The sixteenth is a software request that is set and cleared through the register bus. Each request has its own mask bit and its own steering bit. The steering bit picks which of the two lines the request drives.

A small register bus reads and writes four locations. The status location always shows the raw level of every request, whether or not that request is masked. The mask and steering locations can be rewritten at any time, including while requests are active. The outputs are registered, so any change on a request or in a register reaches the pins one clock later and never glitches. The controller keeps no latched copy of a hardware request. A hardware request is cleared only at the device that raised it.

Top module: `irq_steer_top`

## Requirements
- R1: After reset, both request outputs are high (inactive), the mask reads all ones, the steering register reads zero and the software request is clear.
- R2: When a request is active, unmasked (mask bit 0) and steered to normal (steer bit 0), `irqN` goes low at the first rising edge after the request is seen, and `fiqN` is unaffected.
- R3: A request whose mask bit is 1 drives neither output low.
- R4: A request with steer bit 1 drives only `fiqN`.
- R5: The address map is 0 = status (read-only; writes are ignored), 1 = mask, 2 = steer and 3 = software control. Mask and steer read back the last value written.
- R6: A write to address 3 with data bit 15 = 1 sets the software request, and a write with bit 15 = 0 clears it. The software request appears at status bit 15 and is masked and steered as request 15.
- R7: Nothing is latched. When a hardware request drops, its output returns high one clock later.
- R8: A mask or steer write changes the outputs at the clock edge after the write edge, not at the write edge itself.
- R9: Status bits 14:0 equal the current `srcIn` levels, including those of masked requests.
- R10: Both outputs can be low at the same time when requests are routed to each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | 15 | Hardware interrupt request levels, active high |
| busSel | input | 1 | Register bus access select |
| busWr | input | 1 | Write when 1, read when 0 |
| busAddr | input | 2 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data (combinational) |
| irqN | output | 1 | Normal interrupt request, active low |
| fiqN | output | 1 | Fast interrupt request, active low |

## Verification
A corrupted mask or steering register can be seen through its readback at once. It also shows on the pins one clock after the next matching request appears, as a line that stays silent or as the wrong line going low. A stuck software request shows at status bit 15 on the next read. The tests place each output sample on the exact cycle after a write edge. Because of that, a design whose outputs react one cycle too early or one cycle too late fails a check.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STEER  = 2'd2,
    SEL_SWCTL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    maskWe;
    logic    steerWe;
    logic    swWe;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  output ctrlStrobe_t strobe
);
  regSel_e selAddr;
  logic    wrAccess;

  assign selAddr  = regSel_e'(busAddr);
  assign wrAccess = busSel && busWr;

  always_comb begin
    strobe.rdSel   = selAddr;
    strobe.maskWe  = wrAccess && (selAddr == SEL_MASK);
    strobe.steerWe = wrAccess && (selAddr == SEL_STEER);
    strobe.swWe    = wrAccess && (selAddr == SEL_SWCTL);
  end

  // R5: one write target per access; status is never a write target
  p_single_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.maskWe, strobe.steerWe, strobe.swWe}));
  p_status_ro_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd0) |-> !(strobe.maskWe || strobe.steerWe || strobe.swWe));
endmodule

// File: rtl/irq_steer_dp.sv
module irq_steer_dp
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-2:0] srcIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqN,
  output logic               fiqN
);
  localparam int SW_BIT  = NUM_SRC - 1;
  localparam int NUM_OUT = 2;

  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] steerReg;
  logic               swReq;
  logic [NUM_SRC-1:0] rawActive;
  logic [NUM_SRC-1:0] liveReq;
  logic [NUM_OUT-1:0] outNReg;

  assign rawActive = {swReq, srcIn};
  assign liveReq   = rawActive & ~maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '1;
      steerReg <= '0;
      swReq    <= 1'b0;
    end else begin
      if (strobe.maskWe)  maskReg  <= wrData;
      if (strobe.steerWe) steerReg <= wrData;
      if (strobe.swWe)    swReq    <= wrData[SW_BIT];
    end
  end

  // index 0 = normal line (steer 0), index 1 = fast line (steer 1)
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    logic [NUM_SRC-1:0] routed;
    assign routed = (g == 1) ? (liveReq & steerReg) : (liveReq & ~steerReg);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outNReg[g] <= 1'b1;
      else       outNReg[g] <= ~(|routed);
    end
  end

  assign irqN = outNReg[0];
  assign fiqN = outNReg[1];

  always_comb begin
    unique case (strobe.rdSel)
      SEL_STATUS: rdData = rawActive;
      SEL_MASK:   rdData = maskReg;
      SEL_STEER:  rdData = steerReg;
      SEL_SWCTL:  rdData = {swReq, {(NUM_SRC-1){1'b0}}};
      default:    rdData = '0;
    endcase
  end

  // R3: with everything masked in the previous cycle, neither line is driven
  p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskReg) == '1) |-> (irqN && fiqN));
  // R4: no fast request unless something was steered to fast
  p_fast_needs_steer_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(steerReg) == '0) |-> fiqN);
  // R2: no normal request when everything was steered to fast
  p_normal_needs_steer_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(steerReg) == '1) |-> irqN);
  // R6: software control write
  p_sw_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swWe && wrData[SW_BIT]) |=> swReq);
  p_sw_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swWe && !wrData[SW_BIT]) |=> !swReq);
  // R5: mask holds when not written
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.maskWe |=> $stable(maskReg));
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
  import irq_steer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [14:0] srcIn,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [1:0]  busAddr,
  input  logic [15:0] busWdata,
  output logic [15:0] busRdata,
  output logic        irqN,
  output logic        fiqN
);
  ctrlStrobe_t strobe;

  irq_steer_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  irq_steer_dp #(.NUM_SRC(16)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .wrData (busWdata),
    .strobe (strobe),
    .rdData (busRdata),
    .irqN   (irqN),
    .fiqN   (fiqN)
  );
endmodule

// File: tb/irq_steer_top_tb_top.sv
module irq_steer_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] srcIn = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqN, fiqN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_steer_top dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqN(irqN), .fiqN(fiqN)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setSrc(input logic [14:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irqN", {15'b0, irqN}, 16'h1);
    check("R1 fiqN", {15'b0, fiqN}, 16'h1);
    busRead(2'd1, d); check("R1 mask", d, 16'hFFFF);
    busRead(2'd2, d); check("R1 steer", d, 16'h0000);
    busRead(2'd3, d); check("R1 sw", d, 16'h0000);
  endtask

  task automatic t_masked();
    logic [15:0] d;
    setSrc(15'h0008);
    check("R3 irqN masked", {15'b0, irqN}, 16'h1);
    check("R3 fiqN masked", {15'b0, fiqN}, 16'h1);
    busRead(2'd0, d); check("R9 status raw", d, 16'h0008);
  endtask

  task automatic t_normal();
    busWrite(2'd1, 16'hFFF7);
    @(negedge clk);
    check("R2 irqN low", {15'b0, irqN}, 16'h0);
    check("R2 fiqN high", {15'b0, fiqN}, 16'h1);
    setSrc(15'h0000);
    check("R7 irqN released", {15'b0, irqN}, 16'h1);
  endtask

  task automatic t_fast();
    logic [15:0] d;
    busWrite(2'd2, 16'h0008);
    busRead(2'd2, d); check("R5 steer readback", d, 16'h0008);
    setSrc(15'h0008);
    check("R4 fiqN low", {15'b0, fiqN}, 16'h0);
    check("R4 irqN high", {15'b0, irqN}, 16'h1);
  endtask

  task automatic t_both();
    busWrite(2'd1, 16'hFFD7);
    setSrc(15'h0028);
    check("R10 irqN low", {15'b0, irqN}, 16'h0);
    check("R10 fiqN low", {15'b0, fiqN}, 16'h0);
  endtask

  task automatic t_reconfig();
    busWrite(2'd1, 16'hFFDF);
    check("R8 fiqN at write edge", {15'b0, fiqN}, 16'h0);
    @(negedge clk);
    check("R8 fiqN after write", {15'b0, fiqN}, 16'h1);
    check("R8 irqN kept", {15'b0, irqN}, 16'h0);
  endtask

  task automatic t_software();
    logic [15:0] d;
    setSrc(15'h0000);
    busWrite(2'd3, 16'h8000);
    busRead(2'd0, d); check("R6 status sw", d, 16'h8000);
    check("R6 sw masked irqN", {15'b0, irqN}, 16'h1);
    busWrite(2'd1, 16'h7FFF);
    @(negedge clk);
    check("R6 sw irqN low", {15'b0, irqN}, 16'h0);
    busWrite(2'd3, 16'h7FFF);
    @(negedge clk);
    check("R6 sw cleared irqN", {15'b0, irqN}, 16'h1);
    busRead(2'd0, d); check("R6 status cleared", d, 16'h0000);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    busWrite(2'd0, 16'h1234);
    busRead(2'd0, d); check("R5 status ignores write", d, 16'h0000);
    busRead(2'd1, d); check("R5 mask readback", d, 16'h7FFF);
    busRead(2'd2, d); check("R5 steer unchanged", d, 16'h0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_normal();
    t_fast();
    t_both();
    t_reconfig();
    t_software();
    t_readonly();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule